// File: doc/BRIEF.md
# Strobe-Qualified Parallel Bus Capture

This block moves a multi-bit parallel word from a foreign clock domain into the local clock domain. It does not pass every data line through its own synchronizer. A single strobe line announces that the bus has settled. Only that strobe goes through a chain of flip-flops clocked by the local clock. When the synchronized strobe rises, the whole bus is loaded into a holding register in one step. The captured word can therefore never mix old and new bits.

The upper bits of the captured word act as a select field. They are compared with a locally configured address, which is itself registered on the local clock before use, and the result is raised as a match flag. A one-cycle valid pulse follows each capture. The sender must raise the strobe only after the bus is stable. It must also keep the bus unchanged for several local clock cycles while the capture completes.

Top module: `qualified_bus_capture`

## Requirements
- R1: While reset is asserted and in the cycle after it, `capturedWord` is all zeros and `wordValid` and `selectMatch` are low.
- R2: A strobe that rises between two clock edges, with the bus stable, makes `wordValid` high after the third rising clock edge (SYNC_DEPTH+1 edges at the default depth of 2). From that edge `capturedWord` holds the whole bus value. Before that edge `wordValid` stays low.
- R3: Each assertion of the strobe gives exactly one `wordValid` pulse of one clock cycle, however long the strobe stays high.
- R4: `capturedWord` changes only in a cycle where `wordValid` is high. Bus changes made while the strobe is held high after a capture, or while it is low, do not alter `capturedWord`.
- R5: `selectMatch` is 1 when bits [7:2] of the captured word equal the 6-bit `localAddr`, and 0 otherwise. `selectMatch` changes only in a cycle where `wordValid` is high.
- R6: A strobe that is already high when reset is released causes no capture. The first capture after reset needs the strobe to be seen low and then high.
- R7: Two strobe assertions separated by a low period give two separate valid pulses. Each pulse carries the bus value present at its own assertion, including a change of every bit at once (0x00 to 0xFF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Active-high synchronous reset |
| strobeAsync | input | 1 | Bus-valid strobe from the foreign domain |
| busAsync | input | BUS_W | Parallel data bus from the foreign domain |
| localAddr | input | ADDR_W | Static local address setting |
| capturedWord | output | BUS_W | Word held by the last capture |
| wordValid | output | 1 | One-cycle pulse after each capture |
| selectMatch | output | 1 | Select field of the captured word equals the local address |

## Verification
The capture path is driven with a matching word, a non-matching word and an all-bits flip from 0x00 to 0xFF. These tell a coherent, field-correct load apart from a partial or mis-compared one. A long strobe with the bus changed in mid-hold separates a single edge-triggered load from a level-triggered one. A strobe held high across reset release checks that a level already present at startup is not counted as an edge. Back-to-back assertions confirm that the edge detector re-arms between captures.

// File: rtl/capture_pkg.sv
package capture_pkg;
  typedef struct packed {
    logic loadWord;
  } captureCtrl_t;
endpackage

// File: rtl/capture_ctrl.sv
module capture_ctrl
  import capture_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strobeAsync,
  output captureCtrl_t ctrl
);
  localparam int EffDepth = (SYNC_DEPTH < 2) ? 2 : SYNC_DEPTH;

  logic [EffDepth-1:0] syncQ;
  logic                histQ;

  // Stages preset to the asserted level so that a strobe already high at
  // reset release never looks like a fresh edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      syncQ <= '1;
      histQ <= 1'b1;
    end else begin
      syncQ <= {syncQ[EffDepth-2:0], strobeAsync};
      histQ <= syncQ[EffDepth-1];
    end
  end

  always_comb begin
    ctrl.loadWord = syncQ[EffDepth-1] & ~histQ;
  end
endmodule

// File: rtl/capture_datapath.sv
module capture_datapath
  import capture_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  captureCtrl_t      ctrl,
  input  logic [BUS_W-1:0]  busAsync,
  input  logic [ADDR_W-1:0] localAddr,
  output logic [BUS_W-1:0]  capturedWord,
  output logic              wordValid,
  output logic              selectMatch
);
  localparam int SelLsb = BUS_W - ADDR_W;

  logic [ADDR_W-1:0] addrQ;
  logic [BUS_W-1:0]  wordQ;
  logic              validQ;
  logic              matchQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ  <= '0;
      wordQ  <= '0;
      validQ <= 1'b0;
      matchQ <= 1'b0;
    end else begin
      addrQ  <= localAddr;
      validQ <= ctrl.loadWord;
      if (ctrl.loadWord) begin
        wordQ  <= busAsync;
        matchQ <= (busAsync[BUS_W-1:SelLsb] == addrQ);
      end
    end
  end

  assign capturedWord = wordQ;
  assign wordValid    = validQ;
  assign selectMatch  = matchQ;
endmodule

// File: rtl/qualified_bus_capture.sv
module qualified_bus_capture
  import capture_pkg::*;
#(
  parameter int BUS_W      = 8,
  parameter int ADDR_W     = 6,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobeAsync,
  input  logic [BUS_W-1:0]  busAsync,
  input  logic [ADDR_W-1:0] localAddr,
  output logic [BUS_W-1:0]  capturedWord,
  output logic              wordValid,
  output logic              selectMatch
);
  captureCtrl_t ctrl;

  capture_ctrl #(.SYNC_DEPTH(SYNC_DEPTH)) uCtrl (
    .clk(clk), .rst(rst), .strobeAsync(strobeAsync), .ctrl(ctrl)
  );

  capture_datapath #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) uData (
    .clk(clk), .rst(rst), .ctrl(ctrl), .busAsync(busAsync),
    .localAddr(localAddr), .capturedWord(capturedWord),
    .wordValid(wordValid), .selectMatch(selectMatch)
  );
endmodule

// File: rtl/capture_checker.sv
module capture_checker #(
  parameter int BUS_W  = 8,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] localAddr,
  input logic [BUS_W-1:0]  capturedWord,
  input logic              wordValid,
  input logic              selectMatch
);
  localparam int SelLsb = BUS_W - ADDR_W;

  // R3
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    wordValid |=> !wordValid);

  // R4
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wordValid |-> $stable(capturedWord));

  // R5
  match_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wordValid |-> $stable(selectMatch));

  // R5
  match_value_chk: assert property (@(posedge clk) disable iff (rst)
    wordValid |-> (selectMatch == (capturedWord[BUS_W-1:SelLsb] == $past(localAddr, 2))));
endmodule

bind qualified_bus_capture capture_checker #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rst(rst), .localAddr(localAddr), .capturedWord(capturedWord),
  .wordValid(wordValid), .selectMatch(selectMatch)
);

// File: tb/tb_qualified_bus_capture.sv
module tb_qualified_bus_capture;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       strobeAsync = 1'b0;
  logic [7:0] busAsync = 8'h00;
  logic [5:0] localAddr = 6'h00;
  logic [7:0] capturedWord;
  logic       wordValid;
  logic       selectMatch;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  qualified_bus_capture dut (
    .clk(clk), .rst(rst), .strobeAsync(strobeAsync), .busAsync(busAsync),
    .localAddr(localAddr), .capturedWord(capturedWord),
    .wordValid(wordValid), .selectMatch(selectMatch)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // Raise strobe at a negedge; valid expected at 3rd negedge after.
  task automatic captureWord(input logic [7:0] data, input int holdCycles, input string tag);
    logic expMatch;
    expMatch = (data[7:2] == localAddr);
    @(negedge clk);
    busAsync = data;
    @(negedge clk);
    strobeAsync = 1'b1;
    @(negedge clk);
    check(wordValid == 1'b0, {tag, " R2 early1"}, wordValid, 0);
    @(negedge clk);
    check(wordValid == 1'b0, {tag, " R2 early2"}, wordValid, 0);
    @(negedge clk);
    check(wordValid == 1'b1, {tag, " R2 valid"}, wordValid, 1);
    check(capturedWord == data, {tag, " R2 word"}, capturedWord, data);
    check(selectMatch == expMatch, {tag, " R5 match"}, selectMatch, expMatch);
    @(negedge clk);
    check(wordValid == 1'b0, {tag, " R3 one cycle"}, wordValid, 0);
    repeat (holdCycles) @(negedge clk);
    strobeAsync = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic testReset();
    doReset();
    @(negedge clk);
    check(capturedWord == 8'h00, "R1 word", capturedWord, 0);
    check(wordValid == 1'b0, "R1 valid", wordValid, 0);
    check(selectMatch == 1'b0, "R1 match", selectMatch, 0);
  endtask

  task automatic testMatchAndMismatch();
    localAddr = 6'h29;
    repeat (2) @(negedge clk);
    captureWord(8'hA5, 1, "match");
    captureWord(8'h5A, 1, "mismatch");
  endtask

  task automatic testLongHold();
    int pulses;
    captureWord(8'h3C, 0, "long");
    // strobe already dropped by captureWord; run a fresh long hold here
    pulses = 0;
    @(negedge clk);
    busAsync = 8'hC3;
    @(negedge clk);
    strobeAsync = 1'b1;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      if (wordValid) pulses++;
      if (i == 6) busAsync = 8'h11;
    end
    check(pulses == 1, "R3 long hold pulses", pulses, 1);
    check(capturedWord == 8'hC3, "R4 change during hold", capturedWord, 8'hC3);
    strobeAsync = 1'b0;
    busAsync = 8'h77;
    pulses = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (wordValid) pulses++;
    end
    check(pulses == 0, "R4 no pulse while low", pulses, 0);
    check(capturedWord == 8'hC3, "R4 change while low", capturedWord, 8'hC3);
  endtask

  task automatic testStrobeAtReset();
    int pulses;
    strobeAsync = 1'b1;
    busAsync = 8'h96;
    doReset();
    pulses = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (wordValid) pulses++;
    end
    check(pulses == 0, "R6 no capture", pulses, 0);
    check(capturedWord == 8'h00, "R6 word untouched", capturedWord, 0);
    strobeAsync = 1'b0;
    repeat (4) @(negedge clk);
    captureWord(8'h96, 1, "R6 after low");
  endtask

  task automatic testBackToBack();
    localAddr = 6'h3F;
    repeat (2) @(negedge clk);
    captureWord(8'h00, 0, "R7 first");
    captureWord(8'hFF, 0, "R7 flip");
    check(capturedWord == 8'hFF, "R7 held after", capturedWord, 8'hFF);
  endtask

  initial begin
    testReset();
    testMatchAndMismatch();
    testLongHold();
    testStrobeAtReset();
    testBackToBack();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule